// File: doc/BRIEF.md
# Video Memory Slot Scheduler

This block decides who uses the single video memory port in each access slot. Two requesters compete for it: a CPU that works through a one-byte data latch and an auto-incrementing address, and a drawing engine. The block keeps a column counter that runs every clock and a row counter that advances when the column wraps. Each requester has a deadline, stored as an absolute column number. A requester may use a slot only once the column has reached its deadline.

On the CPU side, loading a new address queues a read. Supplying a data byte queues a write. Either event sets the CPU deadline to the current column plus a fixed access delay. The drawing engine sets its own deadline by pulsing an arm input together with an offset. At every line wrap, both deadlines are lowered by the line length, and a result below zero becomes zero. This way, a deadline that crosses the end of a line falls in the right column of the next line.

A status byte reports whether the CPU queue is empty, vertical blank, horizontal blank, and whether a drawing command is busy.

Top module: `vram_slot_sched`

## Requirements
- R1: While reset is asserted, `col` and `row` are 0, `rd_data` and `mem_addr` are 0, no grant is raised, and `status` reads 0x80.
- R2: `col` counts up by one every clock from 0 to CPL-1, then returns to 0. At that wrap, `row` advances by one, modulo LINES.
- R3: A pulse on `addr_we` loads `addr_in` and queues a read. A pulse on `data_we` loads `data_in` into the data latch and queues a write. If both pulse in the same cycle, the address loads and a write is queued. Either event sets the CPU deadline to the current column plus ACCESS_DELAY.
- R4: `cpu_grant` is high only in a cycle where `slot_stb` is high, a CPU access is queued, and `col` is at or beyond the CPU deadline.
- R5: A granted read loads `mem_rdata` into the latch, which is visible on `rd_data`. A granted write drives `mem_we` high with `mem_wdata` equal to the latch. Either kind of grant empties the queue and increments `mem_addr` by one, modulo 2^ADDR_W.
- R6: At each wrap, every deadline is lowered by CPL, with a floor of zero. A request made in the wrap cycle itself gets max(0, col+delay-CPL). For example, with CPL=40 and delay 6, a request at column 38 becomes eligible at column 4 of the next line, and a request at column 39 becomes eligible at column 5.
- R7: `draw_grant` is high when `slot_stb` and `draw_req` are high, `col` is at or beyond the draw deadline, and `cpu_grant` is low. A `draw_arm` pulse sets the draw deadline to `col` + `draw_dly`. At most one grant is raised per cycle.
- R8: `status` bit 7 is 1 when no CPU access is queued. Bit 6 is 1 when `row` >= VB_ROW. Bit 5 is 1 when `col` >= HB_COL. Bit 0 equals `draw_busy`. Bits 4 to 1 are 0.
- R9: A grant and a new CPU request may fall in the same cycle. The grant completes using the old address and old latch value. The new request then replaces the queue, a loaded address wins over the increment, and a new data byte wins over a read's latch load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_stb | input | 1 | Memory access slot available this cycle |
| addr_we | input | 1 | Load address and queue a read |
| addr_in | input | ADDR_W | New address |
| data_we | input | 1 | Load data byte and queue a write |
| data_in | input | 8 | CPU data byte |
| draw_req | input | 1 | Drawing engine wants a slot |
| draw_arm | input | 1 | Set the draw deadline |
| draw_dly | input | DRAW_DLY_W | Offset for the draw deadline |
| draw_busy | input | 1 | Drawing command in progress |
| mem_rdata | input | 8 | Read data at `mem_addr` (combinational memory) |
| cpu_grant | output | 1 | CPU access performed this cycle |
| draw_grant | output | 1 | Slot handed to drawing engine |
| mem_addr | output | ADDR_W | CPU address |
| mem_we | output | 1 | Queued CPU access is a write |
| mem_wdata | output | 8 | Byte for a CPU write |
| rd_data | output | 8 | Data latch contents |
| status | output | 8 | Status byte |
| col | output | COL_W | Current column |
| row | output | ROW_W | Current row |

## Verification
Two kinds of event can land in the same cycle.

The first is a line wrap together with a deadline: either a request made in the wrap cycle, or one made just before it. Column-targeted pulses are issued at the last two columns of a line, and the grant must appear at exactly column 4 or column 5 of the next line, never earlier.

The second is a CPU grant together with a new address or data load. The bench lines up a delayed write with a simultaneous address load. It then judges the old write on the memory outputs and the new read on the address and queue flag one cycle later.

Long random stretches beyond these directed cases are compared against a behavioural model on every clock.

// File: rtl/vss_pkg.sv
package vss_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;

  localparam int ST_IDLE  = 7;
  localparam int ST_VBLK  = 6;
  localparam int ST_HBLK  = 5;
  localparam int ST_DRAW  = 0;
endpackage

// File: rtl/vss_timing.sv
module vss_timing #(
  parameter int CPL    = 342,
  parameter int LINES  = 262,
  parameter int VB_ROW = 192,
  parameter int HB_COL = 256,
  parameter int COL_W  = $clog2(CPL),
  parameter int ROW_W  = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row,
  output logic             wrap,
  output logic             vblank,
  output logic             hblank
);
  logic [COL_W-1:0] col_d;
  logic [ROW_W-1:0] row_d;

  assign wrap   = (col == COL_W'(CPL - 1));
  assign vblank = (row >= ROW_W'(VB_ROW));
  assign hblank = (col >= COL_W'(HB_COL));

  always_comb begin
    col_d = col + 1'b1;
    row_d = row;
    if (wrap) begin
      col_d = '0;
      row_d = (row == ROW_W'(LINES - 1)) ? '0 : row + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else begin
      col <= col_d;
      row <= row_d;
    end
  end
endmodule

// File: rtl/vss_deadline.sv
module vss_deadline #(
  parameter int CPL   = 342,
  parameter int COL_W = 9,
  parameter int OFS_W = 5,
  parameter int DL_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [OFS_W-1:0] ofs,
  input  logic [COL_W-1:0] col,
  input  logic             wrap,
  output logic             eligible
);
  logic [DL_W-1:0] dl_q, dl_d, cand;
  logic            dl_en;

  assign eligible = (DL_W'(col) >= dl_q);
  assign dl_en    = arm | wrap;

  always_comb begin
    cand = arm ? (DL_W'(col) + DL_W'(ofs)) : dl_q;
    dl_d = cand;
    if (wrap) dl_d = (cand >= DL_W'(CPL)) ? (cand - DL_W'(CPL)) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dl_q <= '0;
    else if (dl_en) dl_q <= dl_d;
  end
endmodule

// File: rtl/vss_cpu_port.sv
module vss_cpu_port
  import vss_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_we,
  input  logic [7:0]        data_in,
  input  logic              grant,
  input  logic [7:0]        mem_rdata,
  output acc_e              pend,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        latch
);
  acc_e              pend_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        latch_d;
  logic              addr_en, latch_en, pend_en;

  always_comb begin
    pend_d  = pend;
    addr_d  = addr;
    latch_d = latch;
    if (grant) begin
      if (pend == ACC_READ) latch_d = mem_rdata;
      pend_d = ACC_NONE;
      addr_d = addr + 1'b1;
    end
    if (addr_we) begin
      addr_d = addr_in;
      pend_d = ACC_READ;
    end
    if (data_we) begin
      latch_d = data_in;
      pend_d  = ACC_WRITE;
    end
  end

  assign addr_en  = grant | addr_we;
  assign latch_en = (grant & (pend == ACC_READ)) | data_we;
  assign pend_en  = grant | addr_we | data_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= ACC_NONE;
      addr  <= '0;
      latch <= '0;
    end else begin
      if (pend_en)  pend  <= pend_d;
      if (addr_en)  addr  <= addr_d;
      if (latch_en) latch <= latch_d;
    end
  end
endmodule

// File: rtl/vram_slot_sched.sv
module vram_slot_sched
  import vss_pkg::*;
#(
  parameter int CPL          = 342,
  parameter int LINES        = 262,
  parameter int VB_ROW       = 192,
  parameter int HB_COL       = 256,
  parameter int ACCESS_DELAY = 16,
  parameter int DRAW_DLY_W   = 5,
  parameter int ADDR_W       = 14,
  parameter int COL_W        = $clog2(CPL),
  parameter int ROW_W        = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slot_stb,
  input  logic                  addr_we,
  input  logic [ADDR_W-1:0]     addr_in,
  input  logic                  data_we,
  input  logic [7:0]            data_in,
  input  logic                  draw_req,
  input  logic                  draw_arm,
  input  logic [DRAW_DLY_W-1:0] draw_dly,
  input  logic                  draw_busy,
  input  logic [7:0]            mem_rdata,
  output logic                  cpu_grant,
  output logic                  draw_grant,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_we,
  output logic [7:0]            mem_wdata,
  output logic [7:0]            rd_data,
  output logic [7:0]            status,
  output logic [COL_W-1:0]      col,
  output logic [ROW_W-1:0]      row
);
  localparam int DRAW_MAX  = (1 << DRAW_DLY_W) - 1;
  localparam int MAX_OFS   = (ACCESS_DELAY > DRAW_MAX) ? ACCESS_DELAY : DRAW_MAX;
  localparam int DL_W      = $clog2(CPL + MAX_OFS) + 1;
  localparam int CPU_OFS_W = $clog2(ACCESS_DELAY + 1);

  logic wrap, vblank, hblank;
  logic cpu_ok, draw_ok, cpu_arm;
  acc_e pend;

  vss_timing #(
    .CPL(CPL), .LINES(LINES), .VB_ROW(VB_ROW), .HB_COL(HB_COL),
    .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .col(col), .row(row),
    .wrap(wrap), .vblank(vblank), .hblank(hblank)
  );

  assign cpu_arm = addr_we | data_we;

  vss_deadline #(
    .CPL(CPL), .COL_W(COL_W), .OFS_W(CPU_OFS_W), .DL_W(DL_W)
  ) u_cpu_dl (
    .clk(clk), .rst_n(rst_n), .arm(cpu_arm),
    .ofs(CPU_OFS_W'(ACCESS_DELAY)), .col(col), .wrap(wrap),
    .eligible(cpu_ok)
  );

  vss_deadline #(
    .CPL(CPL), .COL_W(COL_W), .OFS_W(DRAW_DLY_W), .DL_W(DL_W)
  ) u_draw_dl (
    .clk(clk), .rst_n(rst_n), .arm(draw_arm),
    .ofs(draw_dly), .col(col), .wrap(wrap),
    .eligible(draw_ok)
  );

  vss_cpu_port #(.ADDR_W(ADDR_W)) u_cpu (
    .clk(clk), .rst_n(rst_n),
    .addr_we(addr_we), .addr_in(addr_in),
    .data_we(data_we), .data_in(data_in),
    .grant(cpu_grant), .mem_rdata(mem_rdata),
    .pend(pend), .addr(mem_addr), .latch(rd_data)
  );

  assign cpu_grant  = slot_stb & (pend != ACC_NONE) & cpu_ok;
  assign draw_grant = slot_stb & draw_req & draw_ok & ~cpu_grant;
  assign mem_we     = (pend == ACC_WRITE);
  assign mem_wdata  = rd_data;

  always_comb begin
    status          = '0;
    status[ST_IDLE] = (pend == ACC_NONE);
    status[ST_VBLK] = vblank;
    status[ST_HBLK] = hblank;
    status[ST_DRAW] = draw_busy;
  end
endmodule

// File: rtl/vss_checker.sv
module vss_checker #(
  parameter int CPL   = 342,
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_stb,
  input logic             addr_we,
  input logic             data_we,
  input logic             draw_req,
  input logic             cpu_grant,
  input logic             draw_grant,
  input logic             mem_we,
  input logic [7:0]       status,
  input logic [COL_W-1:0] col
);
  a_r7_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_grant && draw_grant));

  a_r4_grant_needs_queue: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_grant |-> (slot_stb && !status[7]));

  a_r7_draw_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    draw_grant |-> (slot_stb && draw_req));

  a_r2_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (col == COL_W'(CPL - 1)) |=> (col == '0));

  a_r5_grant_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_grant && !addr_we && !data_we) |=> status[7]);

  a_r3_read_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_we && !data_we) |=> (!status[7] && !mem_we));

  a_r9_write_queued: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> (!status[7] && mem_we));
endmodule

bind vram_slot_sched vss_checker #(.CPL(CPL), .COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .addr_we(addr_we),
  .data_we(data_we), .draw_req(draw_req), .cpu_grant(cpu_grant),
  .draw_grant(draw_grant), .mem_we(mem_we), .status(status), .col(col)
);

// File: tb/vram_slot_sched_tb.sv
module vram_slot_sched_tb;
  localparam int CPL = 40, LINES = 5, VB_ROW = 3, HB_COL = 32;
  localparam int DLY = 6, DW = 4, AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_stb = 0, addr_we = 0, data_we = 0, draw_req = 0, draw_arm = 0, draw_busy = 0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] data_in = '0;
  logic [DW-1:0] draw_dly = '0;
  logic [7:0] mem_rdata;
  logic cpu_grant, draw_grant, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, rd_data, status;
  logic [5:0] col;
  logic [2:0] row;

  logic [7:0] mem [256];
  int checks = 0, errors = 0;
  int m_col, m_row, m_q, m_cdl, m_ddl, m_addr, m_buf;
  bit e_cg, e_dg;

  always #10 clk = ~clk;

  vram_slot_sched #(.CPL(CPL), .LINES(LINES), .VB_ROW(VB_ROW), .HB_COL(HB_COL),
    .ACCESS_DELAY(DLY), .DRAW_DLY_W(DW), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .addr_we(addr_we),
    .addr_in(addr_in), .data_we(data_we), .data_in(data_in),
    .draw_req(draw_req), .draw_arm(draw_arm), .draw_dly(draw_dly),
    .draw_busy(draw_busy), .mem_rdata(mem_rdata), .cpu_grant(cpu_grant),
    .draw_grant(draw_grant), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .rd_data(rd_data), .status(status),
    .col(col), .row(row));

  assign mem_rdata = mem[mem_addr];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rebase(input int v);
    return (v >= CPL) ? v - CPL : 0;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_col = 0; m_row = 0; m_q = 0; m_cdl = 0; m_ddl = 0; m_addr = 0; m_buf = 0;
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    end else begin
      bit cg, wr;
      cg = slot_stb && m_q != 0 && m_col >= m_cdl;
      wr = (m_col == CPL - 1);
      if (cg) begin
        if (m_q == 1) m_buf = mem[m_addr];
        else mem[m_addr] = 8'(m_buf);
        m_q = 0;
        m_addr = (m_addr + 1) % 256;
      end
      if (addr_we) begin m_addr = addr_in; m_q = 1; m_cdl = m_col + DLY; end
      if (data_we) begin m_buf = data_in; m_q = 2; m_cdl = m_col + DLY; end
      if (draw_arm) m_ddl = m_col + draw_dly;
      if (wr) begin
        m_cdl = rebase(m_cdl); m_ddl = rebase(m_ddl);
        m_col = 0; m_row = (m_row + 1) % LINES;
      end else m_col++;
    end
  end

  // per-cycle comparison, mid low phase
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      int exp_st;
      e_cg = slot_stb && m_q != 0 && m_col >= m_cdl;
      e_dg = slot_stb && draw_req && !e_cg && m_col >= m_ddl;
      exp_st = ((m_q == 0) ? 8'h80 : 0) | ((m_row >= VB_ROW) ? 8'h40 : 0) |
               ((m_col >= HB_COL) ? 8'h20 : 0) | (draw_busy ? 1 : 0);
      check(col == 6'(m_col) && row == 3'(m_row), "R2 col/row", {row, col}, {m_row[2:0], m_col[5:0]});
      check(cpu_grant == e_cg, "R4 cpu_grant", cpu_grant, e_cg);
      check(draw_grant == e_dg, "R7 draw_grant", draw_grant, e_dg);
      check(status == 8'(exp_st), "R8 status", status, exp_st);
      check(mem_addr == 8'(m_addr) && rd_data == 8'(m_buf), "R5 addr/latch",
            {mem_addr, rd_data}, {m_addr[7:0], m_buf[7:0]});
      check(mem_we == (m_q == 2) && mem_wdata == 8'(m_buf), "R3 write queued",
            {mem_we, mem_wdata}, {(m_q == 2), m_buf[7:0]});
    end
  end

  task automatic wait_col(input int c);
    while (m_col != c) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #5;
    // R1: reset state
    check(col == 0 && row == 0 && status == 8'h80 && !cpu_grant && !draw_grant
          && rd_data == 0 && mem_addr == 0, "R1 reset", {status, col}, 16'h8000);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: request two columns before wrap, eligible at column 4
    slot_stb = 1;
    wait_col(CPL - 2);
    addr_we = 1; addr_in = 8'h10;
    @(negedge clk); addr_we = 0;
    wait_col(0);
    for (int k = 0; k <= 4; k++) begin
      #5 check(cpu_grant == (k == 4), "R6 pre-wrap deadline", cpu_grant, k == 4);
      @(negedge clk);
    end
    // R6: request in the wrap cycle, eligible at column 5
    wait_col(CPL - 1);
    addr_we = 1; addr_in = 8'h20;
    @(negedge clk); addr_we = 0;
    for (int k = 0; k <= 5; k++) begin
      #5 check(cpu_grant == (k == 5), "R6 wrap-cycle deadline", cpu_grant, k == 5);
      @(negedge clk);
    end

    // R9: write granted while a new address is loaded
    slot_stb = 0;
    data_we = 1; data_in = 8'hA5;
    @(negedge clk); data_we = 0;
    repeat (8) @(negedge clk);
    slot_stb = 1; addr_we = 1; addr_in = 8'h50;
    #5 check(cpu_grant && mem_we && mem_wdata == 8'hA5, "R9 old write granted",
             {cpu_grant, mem_we, mem_wdata}, {2'b11, 8'hA5});
    @(negedge clk); addr_we = 0; slot_stb = 0;
    #5 check(mem_addr == 8'h50 && !status[7] && !mem_we, "R9 new read queued",
             {mem_addr, status[7], mem_we}, {8'h50, 2'b00});
    @(negedge clk);

    // random traffic, compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      slot_stb  = ($urandom % 2) == 0;
      addr_we   = ($urandom % 19) == 0;
      data_we   = ($urandom % 17) == 0;
      addr_in   = 8'($urandom);
      data_in   = 8'($urandom);
      draw_req  = ($urandom % 3) != 0;
      draw_arm  = ($urandom % 13) == 0;
      draw_dly  = 4'($urandom);
      draw_busy = ($urandom % 4) == 0;
      @(negedge clk);
    end
    slot_stb = 0; addr_we = 0; data_we = 0; draw_req = 0; draw_arm = 0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule